// File: doc/BRIEF.md
# Mode-Switched Interrupt Priority Router

This block gathers level-sensitive interrupt requests from two peripheral interface controllers, an Ethernet controller, a two-channel serial controller and a non-maskable source. It presents them to a 68k-style processor as one 3-bit priority level and a matching autovector number. A mode pin selects one of two source-to-level maps. In the classic map, the Ethernet request does not enter the priority logic. It is instead copied onto a side line that feeds a slot interrupt input of the second peripheral controller.

Each request is handled on its edges. When an input rises, the pending bit of the level it maps to is set. When the input falls, that bit is cleared. The map used is the one in force when the edge happens. The non-maskable source is a short trigger pulse. A counter stretches it into a request that lasts a fixed time, 100 ms by default, derived from the clock frequency parameter. All outputs are registered.

Top module: `irq_prio_router`

## Requirements
- R1: With the registered mode low (alternate map), a change on a request updates the pending bit of its level: controller 1 is level 6, controller 2 is level 2, Ethernet is level 3, serial is level 4 and the stretched NMI is level 7.
- R2: With the registered mode high (classic map), controller 1 is level 1, controller 2 is level 2, serial is level 4 and the NMI is level 7. An Ethernet change sets no pending bit. Its new value is copied to `slotIrq` instead, and `slotIrq` changes at no other time except reset.
- R3: A rising edge sets the mapped pending bit and a falling edge clears it. `cpuLevel` is the highest level whose bit is set, or 0 when no bit is set.
- R4: `cpuVector` is 24 plus `cpuLevel` when the level is non-zero, so level 7 gives 31. It is 0 when the level is 0.
- R5: The two serial channel requests are ORed into one source. Handing the request from one channel to the other in the same cycle causes no edge.
- R6: A `nmiTrig` sample of 1 starts an NMI hold of HOLD_MS milliseconds, which is (CLK_HZ/1000)*HOLD_MS cycles, counted from the edge after the trigger. A new trigger during the hold restarts the full count. When the hold ends, the NMI request falls on its own.
- R7: `modeSel` is registered. An edge sampled at clock k is mapped with the mode sampled at clock k-1. Changing the mode never moves or clears bits that are already pending.
- R8: A synchronous active-high `rst` clears the pending bits, `cpuLevel`, `cpuVector` and `slotIrq`. It forces the registered mode to the alternate map, cancels any NMI hold, and sets the remembered request values to 0.
- R9: Outputs change one clock after an input edge is sampled. For the NMI, the hold rises one clock after the trigger and the level follows one clock after that.
- R10: A cycle with no request edge leaves all pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| picReq1 | input | 1 | Request from peripheral controller 1 |
| picReq2 | input | 1 | Request from peripheral controller 2 |
| ethReq | input | 1 | Ethernet controller request |
| serReqA | input | 1 | Serial controller channel A request |
| serReqB | input | 1 | Serial controller channel B request |
| nmiTrig | input | 1 | Non-maskable trigger pulse |
| modeSel | input | 1 | Map select: 1 classic, 0 alternate |
| cpuLevel | output | 3 | Priority level presented to the CPU |
| cpuVector | output | 8 | Autovector number for that level |
| slotIrq | output | 1 | Ethernet request diverted in the classic map |

## Verification
Pending bits are the only memory of past edges, so a wrong bit cannot be seen while a higher level is pending. It shows on `cpuLevel` and `cpuVector` one clock after the higher source falls. For that reason the bench drops sources in an order that uncovers each lower level. A pending bit left stale by a mode change persists until the same source makes an edge under the other map. A hold counter that is off by one shows up only at the release edge, so the bench samples the cycle just before release and the cycle just after it, both for a single trigger and for a restarted one.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int NSRC     = 5;
  localparam int NLVL     = 7;
  localparam int VEC_BASE = 24;

  localparam int SRC_PIC1 = 0;
  localparam int SRC_PIC2 = 1;
  localparam int SRC_ETH  = 2;
  localparam int SRC_SER  = 3;
  localparam int SRC_NMI  = 4;

  typedef struct packed {
    logic [NSRC-1:0] chg;
    logic [NSRC-1:0] lvl;
    logic            classic;
  } strobe_t;

  // pending-bit index (level - 1) for a source under a given map
  function automatic logic [2:0] mapBit(input int src, input logic classic);
    logic [2:0] idx;
    case (src)
      SRC_PIC1: idx = classic ? 3'd0 : 3'd5;
      SRC_PIC2: idx = 3'd1;
      SRC_ETH:  idx = 3'd2;
      SRC_SER:  idx = 3'd3;
      default:  idx = 3'd6;
    endcase
    return idx;
  endfunction

  function automatic logic [2:0] topLevel(input logic [NLVL-1:0] pend);
    logic [2:0] lv;
    lv = 3'd0;
    for (int i = 0; i < NLVL; i++)
      if (pend[i]) lv = 3'(i + 1);
    return lv;
  endfunction

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int HOLD_MS = 100
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    picReq1,
  input  logic    picReq2,
  input  logic    ethReq,
  input  logic    serReq,
  input  logic    nmiTrig,
  input  logic    modeSel,
  output strobe_t strb
);

  localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
  localparam int CW       = $clog2(HOLD_CYC + 1);

  logic [NSRC-1:0] prevReq;
  logic [NSRC-1:0] curReq;
  logic            modeQ;
  logic            nmiHold;
  logic [CW-1:0]   holdCnt;

  assign curReq = {nmiHold, serReq, ethReq, picReq2, picReq1};

  always_comb begin
    strb.chg     = curReq ^ prevReq;
    strb.lvl     = curReq;
    strb.classic = modeQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevReq <= '0;
      modeQ   <= 1'b0;
    end else begin
      prevReq <= curReq;
      modeQ   <= modeSel;
    end
  end

  // NMI stretcher: restartable down-counter
  always_ff @(posedge clk) begin
    if (rst) begin
      nmiHold <= 1'b0;
      holdCnt <= '0;
    end else if (nmiTrig) begin
      nmiHold <= 1'b1;
      holdCnt <= CW'(HOLD_CYC - 1);
    end else if (nmiHold) begin
      if (holdCnt == '0) nmiHold <= 1'b0;
      else               holdCnt <= holdCnt - 1'b1;
    end
  end

  // R6: the hold only ever starts from a trigger
  a_r6_hold_from_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(nmiHold) |-> $past(nmiTrig));

  // R6: a trigger always leaves the hold active
  a_r6_trig_holds: assert property (@(posedge clk) disable iff (rst)
    nmiTrig |=> nmiHold);

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strb,
  output logic [2:0] cpuLevel,
  output logic [7:0] cpuVector,
  output logic       slotIrq
);

  logic [NLVL-1:0] pendQ, pendNext;
  logic            slotQ, slotNext;
  logic [2:0]      levelQ, levelNext;
  logic [7:0]      vecQ, vecNext;

  always_comb begin
    pendNext = pendQ;
    slotNext = slotQ;
    for (int s = 0; s < NSRC; s++) begin
      if (strb.chg[s]) begin
        if (s == SRC_ETH && strb.classic) slotNext = strb.lvl[s];
        else                              pendNext[mapBit(s, strb.classic)] = strb.lvl[s];
      end
    end
    levelNext = topLevel(pendNext);
    vecNext   = (levelNext == 3'd0) ? 8'd0 : 8'(VEC_BASE) + {5'd0, levelNext};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ  <= '0;
      slotQ  <= 1'b0;
      levelQ <= 3'd0;
      vecQ   <= 8'd0;
    end else begin
      pendQ  <= pendNext;
      slotQ  <= slotNext;
      levelQ <= levelNext;
      vecQ   <= vecNext;
    end
  end

  assign cpuLevel  = levelQ;
  assign cpuVector = vecQ;
  assign slotIrq   = slotQ;

  // R4: vector register agrees with level register
  a_r4_vector: assert property (@(posedge clk) disable iff (rst)
    cpuVector == ((cpuLevel == 3'd0) ? 8'd0 : 8'(VEC_BASE) + {5'd0, cpuLevel}));

  // R3: level is zero exactly when nothing is pending
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (pendQ == '0) == (cpuLevel == 3'd0));

  // R2: side line moves only under the classic map
  a_r2_slot_classic: assert property (@(posedge clk) disable iff (rst)
    !$stable(slotQ) |-> $past(strb.classic));

  // R10: no edge, no pending change
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (strb.chg == '0) |=> $stable(pendQ));

  // R8: reset leaves outputs idle
  a_r8_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (cpuLevel == 3'd0 && !slotIrq && pendQ == '0));

endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_router_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int HOLD_MS = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       picReq1,
  input  logic       picReq2,
  input  logic       ethReq,
  input  logic       serReqA,
  input  logic       serReqB,
  input  logic       nmiTrig,
  input  logic       modeSel,
  output logic [2:0] cpuLevel,
  output logic [7:0] cpuVector,
  output logic       slotIrq
);

  strobe_t strb;
  logic    serReq;

  assign serReq = serReqA | serReqB;  // R5

  irq_router_ctrl #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .picReq1 (picReq1),
    .picReq2 (picReq2),
    .ethReq  (ethReq),
    .serReq  (serReq),
    .nmiTrig (nmiTrig),
    .modeSel (modeSel),
    .strb    (strb)
  );

  irq_router_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cpuLevel  (cpuLevel),
    .cpuVector (cpuVector),
    .slotIrq   (slotIrq)
  );

endmodule

// File: tb/irq_prio_router_test.sv
module irq_prio_router_test;

  localparam int CLK_HZ  = 10_000;
  localparam int HOLD_MS = 100;
  localparam int HOLD    = (CLK_HZ / 1000) * HOLD_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pic1 = 0, pic2 = 0, eth = 0, serA = 0, serB = 0, trig = 0, mode = 0;
  logic [2:0] lvl;
  logic [7:0] vec;
  logic       slot;

  always #4 clk = ~clk;

  irq_prio_router #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) uut (
    .clk(clk), .rst(rst), .picReq1(pic1), .picReq2(pic2), .ethReq(eth),
    .serReqA(serA), .serReqB(serB), .nmiTrig(trig), .modeSel(mode),
    .cpuLevel(lvl), .cpuVector(vec), .slotIrq(slot)
  );

  int compared = 0, mismatched = 0;
  string phase = "R8";
  bit done = 0;

  // behavioural reference
  int mapAlt[5] = '{6, 2, 3, 4, 7};
  int mapCls[5] = '{1, 2, 0, 4, 7};
  bit [4:0] mPrev, mCur;
  bit [6:0] mPend;
  bit mMode, mHold, mSlot;
  int mCnt, mLevel, mVec, mL;

  always @(posedge clk) begin
    if (rst) begin
      mPrev = 0; mPend = 0; mMode = 0; mHold = 0; mCnt = 0;
      mSlot = 0; mLevel = 0; mVec = 0;
    end else begin
      mCur = {mHold, serA | serB, eth, pic2, pic1};
      for (int s = 0; s < 5; s++) begin
        if (mCur[s] != mPrev[s]) begin
          if (s == 2 && mMode) mSlot = mCur[s];
          else begin
            mL = mMode ? mapCls[s] : mapAlt[s];
            mPend[mL-1] = mCur[s];
          end
        end
      end
      mLevel = 0;
      for (int l = 1; l <= 7; l++) if (mPend[l-1]) mLevel = l;
      mVec = (mLevel == 0) ? 0 : 24 + mLevel;
      mPrev = mCur;
      mMode = mode;
      if (trig) begin mHold = 1; mCnt = HOLD - 1; end
      else if (mHold) begin
        if (mCnt == 0) mHold = 0; else mCnt--;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (int'(lvl) != mLevel || int'(vec) != mVec || slot != mSlot) begin
        mismatched++;
        $display("FAIL %s model: got level %0d vec %0d slot %0d, expected %0d %0d %0d",
                 phase, lvl, vec, slot, mLevel, mVec, mSlot);
      end
    end
  end

  task automatic chk(string req, int el, int ev, int es);
    compared++;
    if (int'(lvl) != el || int'(vec) != ev || int'(slot) != es) begin
      mismatched++;
      $display("FAIL %s: got level %0d vec %0d slot %0d, expected %0d %0d %0d",
               req, lvl, vec, slot, el, ev, es);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R8", 0, 0, 0);
    rst = 0;

    phase = "R1";
    pic1 = 1;
    chk("R9", 0, 0, 0);           // no edge yet
    step(1); chk("R1", 6, 30, 0);
    eth = 1; step(1); chk("R1", 6, 30, 0);
    pic1 = 0; step(1); chk("R3", 3, 27, 0);
    serA = 1; step(1); chk("R1", 4, 28, 0);
    phase = "R5";
    serB = 1; serA = 0; step(1); chk("R5", 4, 28, 0);
    serB = 0; step(1); chk("R5", 3, 27, 0);

    phase = "R6";
    trig = 1; step(1); trig = 0;
    chk("R9", 3, 27, 0);
    step(1); chk("R4", 7, 31, 0);
    step(HOLD - 1); chk("R6", 7, 31, 0);
    step(1); chk("R6", 3, 27, 0);
    trig = 1; step(1); trig = 0;
    step(500);
    trig = 1; step(1); trig = 0;
    step(HOLD - 1); chk("R6", 7, 31, 0);   // restart extended the hold
    step(2); chk("R6", 3, 27, 0);

    phase = "R7";
    mode = 1; step(1);
    eth = 0; step(1); chk("R7", 3, 27, 0);  // stale bit kept
    phase = "R2";
    eth = 1; step(1); chk("R2", 3, 27, 1);
    pic1 = 1; step(1); chk("R2", 3, 27, 1);
    phase = "R7";
    mode = 0; step(1);
    eth = 0; step(1); chk("R7", 1, 25, 1);
    phase = "R2";
    mode = 1; step(1);
    pic2 = 1; step(1); chk("R2", 2, 26, 1);
    eth = 1; step(1);
    eth = 0; step(1); chk("R2", 2, 26, 0);
    trig = 1; step(1); trig = 0;
    step(1); chk("R2", 7, 31, 0);

    phase = "R8";
    rst = 1; pic1 = 0; pic2 = 0; eth = 1; mode = 1;
    step(2); chk("R8", 0, 0, 0);
    rst = 0;
    step(1); chk("R8", 3, 27, 0);          // first edge uses alternate map
    phase = "R10";
    step(HOLD + 5); chk("R10", 3, 27, 0);  // hold was cancelled

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: got no end, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule